// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the byte-wide, memory-mapped control side of a serial port. A processor reaches it through a small register map with byte offsets. Through that map it sets the frame format and the baud divisor, enables the receive and transmit directions, pushes transmit bytes, pops received bytes, and handles two interrupt sources. A separate framing engine does the line timing. It takes transmit bytes through a valid/take handshake and delivers received bytes, together with their parity and framing error bits, through a single-cycle push strobe.

Each direction has its own 16-entry FIFO. Each receive entry keeps three error bits next to its data, so the line status always describes the byte that the next data read will return. A receive byte that arrives while the FIFO is full is dropped, and the next byte that is accepted carries the overrun mark. The receive interrupt condition follows a programmable occupancy mark that can never be lower than half the FIFO, so software normally forces a receive interrupt itself through the flag-set register when a few bytes are waiting.

Top module: `serial_port_regs`

## Requirements
- R1: After reset every register reads zero, except as follows. FIFO status (0x0A) reads 0x84 (bit 2 = RX empty, bit 7 = TX low). Line status (0x02) reads 0x40 while `link_tx_busy` is low. `irq` and `link_tx_valid` are low.
- R2: Registers written at 0x00 (bit 0 block enable), 0x01 (bits [2:0]), 0x03, 0x08, 0x09, 0x0B and 0x1E (bits [1:0]) read back what was written. `link_frame_cfg` carries 0x03. `link_baud_div` is {0x09,0x08}. `link_rx_en` is 0x00 bit 0 AND 0x01 bit 0 with soft reset (0x01 bit 2) low. `link_tx_en` is the same with 0x01 bit 1.
- R3: A write to 0x04 pushes a byte into the TX FIFO. `link_tx_valid` with `link_tx_byte` presents the bytes in write order, and each `link_tx_take` pops one. A write while 16 bytes are held is dropped. FIFO status bit 4 is high when the TX FIFO is full.
- R4: When `link_rx_push` is high and RX is enabled, a byte and its error bits are stored. A read of 0x04 returns the oldest byte and pops it. A read while the FIFO is empty returns 0. A push while the FIFO is full is dropped, and the next accepted byte carries the overrun bit.
- R5: Line status bits [2:0] give {overrun, frame, parity} of the head RX byte (0 when RX is empty). Bit 6 is high when the TX FIFO is empty and `link_tx_busy` is low.
- R6: FIFO config bits [2:0] hold a threshold t and bit 3 selects RX FIFO mode. With bit 3 set, FIFO status bit 3 (RX almost) is high when RX occupancy exceeds 8 + t. With bit 3 clear, it is high whenever RX holds any byte.
- R7: Interrupt bit 0 is TX and bit 1 is RX. Ones written to 0x1D raise the flags and ones written to 0x1C lower them. A clear wins over a set in the same cycle. 0x1F reads the flags AND the enables in 0x1E. `irq` is the OR of those bits.
- R8: The TX flag is raised by hardware while TX is enabled and its FIFO is not full. The RX flag is raised while the RX almost condition holds.
- R9: While the block enable is low or soft reset is high, both FIFOs are held empty, and the flags and the pending overrun mark are cleared. RX pushes and data writes are ignored. The other registers keep their values.
- R10: FIFO status bit 7 is high while the TX FIFO holds at most 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops RX on offset 0x04) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq | output | 1 | Interrupt request |
| link_rx_en | output | 1 | Receive enable to the framing engine |
| link_tx_en | output | 1 | Transmit enable to the framing engine |
| link_frame_cfg | output | 8 | Frame format byte |
| link_baud_div | output | 16 | Baud divisor |
| link_tx_valid | output | 1 | A transmit byte is available |
| link_tx_byte | output | 8 | Head transmit byte |
| link_tx_take | input | 1 | Engine consumes the head transmit byte |
| link_tx_busy | input | 1 | Engine shift register active |
| link_rx_push | input | 1 | Engine delivers a received byte |
| link_rx_byte | input | 8 | Received byte |
| link_rx_err | input | 2 | {frame, parity} error of the received byte |

## Verification
The assertions assume that the bus strobes a single offset at a time and that a read and a write never fall in the same cycle. They also assume that `link_tx_take` is raised only while `link_tx_valid` is high, and that `link_rx_push` is a one-cycle pulse per byte. The stimulus drives every strobe for exactly one clock and leaves an idle cycle between operations. It raises the take strobe only after it has seen a valid byte. Overflow is provoked deliberately, only by pushing a seventeenth byte into a full FIFO.

// File: rtl/sp_pkg.sv
package sp_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_ENABLE   = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTRL     = 5'h01;
  localparam logic [ADDR_W-1:0] A_LSTAT    = 5'h02;
  localparam logic [ADDR_W-1:0] A_FRAME    = 5'h03;
  localparam logic [ADDR_W-1:0] A_DATA     = 5'h04;
  localparam logic [ADDR_W-1:0] A_DIV_LO   = 5'h08;
  localparam logic [ADDR_W-1:0] A_DIV_HI   = 5'h09;
  localparam logic [ADDR_W-1:0] A_FSTAT    = 5'h0A;
  localparam logic [ADDR_W-1:0] A_FCFG     = 5'h0B;
  localparam logic [ADDR_W-1:0] A_FLAG_CLR = 5'h1C;
  localparam logic [ADDR_W-1:0] A_FLAG_SET = 5'h1D;
  localparam logic [ADDR_W-1:0] A_IEN      = 5'h1E;
  localparam logic [ADDR_W-1:0] A_ISTAT    = 5'h1F;

  localparam int NUM_IRQ = 2;
  localparam int IRQ_TX  = 0;
  localparam int IRQ_RX  = 1;

  typedef struct packed {
    logic       ovr;
    logic       frame;
    logic       parity;
    logic [7:0] data;
  } rx_entry_t;

  // RX almost-full condition: mark never below half the FIFO
  function automatic logic rx_over_mark(input int unsigned occ, input int unsigned depth,
                                        input int unsigned thr, input logic fifo_mode);
    if (fifo_mode) return occ > (depth / 2 + thr);
    return occ != 0;
  endfunction

  // TX low-water condition
  function automatic logic tx_low_mark(input int unsigned occ, input int unsigned depth);
    return occ <= depth / 2;
  endfunction
endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    occ;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  assign dout  = mem[rd_ptr];
  assign count = occ;
  assign empty = (occ == '0);
  assign full  = (occ == CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !flush |=> occ == CW'(DEPTH));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0);
endmodule

// File: rtl/sp_irq_flags.sv
module sp_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] enable,
  output logic [N-1:0] flags,
  output logic [N-1:0] masked,
  output logic         any
);
  timeunit 1ns;
  timeprecision 1ps;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (wipe) q <= 1'b0;
      else           q <= (q | hw_set[i] | sw_set[i]) & ~sw_clr[i];
    end
    assign flags[i] = q;

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr[i] |=> !flags[i]);
    assert_soft_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_set[i] && !sw_clr[i] && !wipe |=> flags[i]);
    assert_wipe_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> !flags[i]);
  end

  assign masked = flags & enable;
  assign any    = |masked;
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs #(
  parameter int FIFO_DEPTH = 16,
  parameter int THR_W      = 3,
  localparam int CW        = $clog2(FIFO_DEPTH + 1),
  localparam int RXW       = $bits(sp_pkg::rx_entry_t)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq,
  output logic        link_rx_en,
  output logic        link_tx_en,
  output logic [7:0]  link_frame_cfg,
  output logic [15:0] link_baud_div,
  output logic        link_tx_valid,
  output logic [7:0]  link_tx_byte,
  input  logic        link_tx_take,
  input  logic        link_tx_busy,
  input  logic        link_rx_push,
  input  logic [7:0]  link_rx_byte,
  input  logic [1:0]  link_rx_err
);
  timeunit 1ns;
  timeprecision 1ps;
  import sp_pkg::*;

  // ---------------- configuration registers ----------------
  logic                blk_en;
  logic [2:0]          ctrl_q;
  logic [7:0]          frame_q, div_lo_q, div_hi_q, fcfg_q;
  logic [NUM_IRQ-1:0]  ien_q;

  logic wr_en_hit, wr_ctrl_hit, wr_frame_hit, wr_lo_hit, wr_hi_hit;
  logic wr_fcfg_hit, wr_ien_hit, wr_data_hit, wr_set_hit, wr_clr_hit, rd_data_hit;

  assign wr_en_hit    = bus_wr && bus_addr == A_ENABLE;
  assign wr_ctrl_hit  = bus_wr && bus_addr == A_CTRL;
  assign wr_frame_hit = bus_wr && bus_addr == A_FRAME;
  assign wr_lo_hit    = bus_wr && bus_addr == A_DIV_LO;
  assign wr_hi_hit    = bus_wr && bus_addr == A_DIV_HI;
  assign wr_fcfg_hit  = bus_wr && bus_addr == A_FCFG;
  assign wr_ien_hit   = bus_wr && bus_addr == A_IEN;
  assign wr_data_hit  = bus_wr && bus_addr == A_DATA;
  assign wr_set_hit   = bus_wr && bus_addr == A_FLAG_SET;
  assign wr_clr_hit   = bus_wr && bus_addr == A_FLAG_CLR;
  assign rd_data_hit  = bus_rd && bus_addr == A_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_en   <= 1'b0;
      ctrl_q   <= '0;
      frame_q  <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
      fcfg_q   <= '0;
      ien_q    <= '0;
    end else begin
      if (wr_en_hit)    blk_en   <= bus_wdata[0];
      if (wr_ctrl_hit)  ctrl_q   <= bus_wdata[2:0];
      if (wr_frame_hit) frame_q  <= bus_wdata;
      if (wr_lo_hit)    div_lo_q <= bus_wdata;
      if (wr_hi_hit)    div_hi_q <= bus_wdata;
      if (wr_fcfg_hit)  fcfg_q   <= bus_wdata;
      if (wr_ien_hit)   ien_q    <= bus_wdata[NUM_IRQ-1:0];
    end
  end

  // ---------------- named internal events ----------------
  logic flush, rx_en_eff, tx_en_eff;
  assign flush     = ~blk_en | ctrl_q[2];
  assign rx_en_eff = ~flush & ctrl_q[0];
  assign tx_en_eff = ~flush & ctrl_q[1];

  logic [CW-1:0] rx_count, tx_count;
  logic          rx_empty, rx_full, tx_empty, tx_full;
  rx_entry_t     rx_head, rx_din;
  logic [7:0]    tx_head;
  logic          rx_push_acc, rx_push_ok, rx_drop, rx_pop_req, tx_push_req, tx_pop_req;
  logic          ovr_pend;

  assign rx_push_acc = link_rx_push & rx_en_eff;
  assign rx_push_ok  = rx_push_acc & ~rx_full;
  assign rx_drop     = rx_push_acc & rx_full;
  assign rx_pop_req  = rd_data_hit;
  assign tx_push_req = wr_data_hit & ~flush;
  assign tx_pop_req  = link_tx_take & link_tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovr_pend <= 1'b0;
    else if (flush)      ovr_pend <= 1'b0;
    else if (rx_drop)    ovr_pend <= 1'b1;
    else if (rx_push_ok) ovr_pend <= 1'b0;
  end

  assign rx_din = '{ovr: ovr_pend, frame: link_rx_err[1], parity: link_rx_err[0],
                    data: link_rx_byte};

  // ---------------- FIFOs ----------------
  logic [RXW-1:0] rx_dout_raw;

  sp_fifo #(.WIDTH(RXW), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (rx_push_acc),
    .din   (rx_din),
    .pop   (rx_pop_req),
    .dout  (rx_dout_raw),
    .count (rx_count),
    .empty (rx_empty),
    .full  (rx_full)
  );
  assign rx_head = rx_entry_t'(rx_dout_raw);

  sp_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (tx_push_req),
    .din   (bus_wdata),
    .pop   (tx_pop_req),
    .dout  (tx_head),
    .count (tx_count),
    .empty (tx_empty),
    .full  (tx_full)
  );

  // ---------------- status ----------------
  logic       rx_almost, tx_low, tx_drained;
  logic [2:0] head_err;
  logic [7:0] line_stat, fifo_stat;

  assign rx_almost  = rx_over_mark(32'(rx_count), FIFO_DEPTH, 32'(fcfg_q[THR_W-1:0]), fcfg_q[3]);
  assign tx_low     = tx_low_mark(32'(tx_count), FIFO_DEPTH);
  assign tx_drained = tx_empty & ~link_tx_busy;
  assign head_err   = rx_empty ? 3'b000 : {rx_head.ovr, rx_head.frame, rx_head.parity};
  assign line_stat  = {1'b0, tx_drained, 3'b000, head_err};
  assign fifo_stat  = {tx_low, 2'b00, tx_full, rx_almost, rx_empty, 2'b00};

  // ---------------- interrupts ----------------
  logic [NUM_IRQ-1:0] hw_set, sw_set, sw_clr, irq_flags, irq_masked;

  always_comb begin
    hw_set         = '0;
    hw_set[IRQ_TX] = tx_en_eff & ~tx_full;
    hw_set[IRQ_RX] = rx_almost;
  end
  assign sw_set = wr_set_hit ? bus_wdata[NUM_IRQ-1:0] : '0;
  assign sw_clr = wr_clr_hit ? bus_wdata[NUM_IRQ-1:0] : '0;

  sp_irq_flags #(.N(NUM_IRQ)) i_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wipe   (flush),
    .hw_set (hw_set),
    .sw_set (sw_set),
    .sw_clr (sw_clr),
    .enable (ien_q),
    .flags  (irq_flags),
    .masked (irq_masked),
    .any    (irq)
  );

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ENABLE: bus_rdata = {7'b0, blk_en};
      A_CTRL:   bus_rdata = {5'b0, ctrl_q};
      A_LSTAT:  bus_rdata = line_stat;
      A_FRAME:  bus_rdata = frame_q;
      A_DATA:   bus_rdata = rx_empty ? 8'h00 : rx_head.data;
      A_DIV_LO: bus_rdata = div_lo_q;
      A_DIV_HI: bus_rdata = div_hi_q;
      A_FSTAT:  bus_rdata = fifo_stat;
      A_FCFG:   bus_rdata = fcfg_q;
      A_IEN:    bus_rdata = {{(8-NUM_IRQ){1'b0}}, ien_q};
      A_ISTAT:  bus_rdata = {{(8-NUM_IRQ){1'b0}}, irq_masked};
      default:  bus_rdata = '0;
    endcase
  end

  // ---------------- engine side ----------------
  assign link_rx_en     = rx_en_eff;
  assign link_tx_en     = tx_en_eff;
  assign link_frame_cfg = frame_q;
  assign link_baud_div  = {div_hi_q, div_lo_q};
  assign link_tx_valid  = tx_en_eff & ~tx_empty;
  assign link_tx_byte   = tx_head;

  // ---------------- assertions ----------------
  assert_pop_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_req && !rx_empty && !rx_push_acc && !flush |=> rx_count == CW'($past(rx_count) - 1'b1));
  assert_overrun_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop && !flush |=> ovr_pend);
  assert_overrun_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_ok |=> !ovr_pend);
  assert_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_stat[6] |-> tx_count == '0);
  assert_tx_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[1] |-> !link_tx_valid);
  assert_rx_idle_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) && flush |-> rx_count == '0 && tx_count == '0);
endmodule

// File: tb/test_serial_port_regs.sv
module test_serial_port_regs;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq, link_rx_en, link_tx_en, link_tx_valid;
  logic [7:0]  link_frame_cfg, link_tx_byte;
  logic [15:0] link_baud_div;
  logic        link_tx_take = 1'b0, link_tx_busy = 1'b0, link_rx_push = 1'b0;
  logic [7:0]  link_rx_byte = '0;
  logic [1:0]  link_rx_err = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_port_regs i_serial_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .link_rx_en(link_rx_en),
    .link_tx_en(link_tx_en), .link_frame_cfg(link_frame_cfg), .link_baud_div(link_baud_div),
    .link_tx_valid(link_tx_valid), .link_tx_byte(link_tx_byte), .link_tx_take(link_tx_take),
    .link_tx_busy(link_tx_busy), .link_rx_push(link_rx_push), .link_rx_byte(link_rx_byte),
    .link_rx_err(link_rx_err)
  );

  // {op (0 write, 1 read-compare), addr[4:0], data[7:0]}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 5'h00, 8'h01}, {1'b0, 5'h01, 8'h01}, {1'b1, 5'h01, 8'h01},
    {1'b0, 5'h03, 8'h15}, {1'b1, 5'h03, 8'h15}, {1'b0, 5'h08, 8'h34},
    {1'b0, 5'h09, 8'h12}, {1'b1, 5'h08, 8'h34}, {1'b1, 5'h09, 8'h12},
    {1'b0, 5'h1E, 8'h03}, {1'b1, 5'h1E, 8'h03}, {1'b0, 5'h0B, 8'h8B},
    {1'b1, 5'h0B, 8'h8B}, {1'b1, 5'h00, 8'h01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_in(input logic [7:0] b, input logic [1:0] e);
    @(negedge clk);
    link_rx_byte = b; link_rx_err = e; link_rx_push = 1'b1;
    @(negedge clk);
    link_rx_push = 1'b0;
  endtask

  task automatic take;
    @(negedge clk);
    link_tx_take = 1'b1;
    @(negedge clk);
    link_tx_take = 1'b0;
  endtask

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    settle;
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", link_tx_valid, 0);
    chk("R1 baud", link_baud_div, 0);
    rd_chk("R1 enable", 5'h00, 8'h00);
    rd_chk("R1 fifo status", 5'h0A, 8'h84);
    rd_chk("R1 line status", 5'h02, 8'h40);
    rd_chk("R1 int status", 5'h1F, 8'h00);

    // R2: register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][13]) rd_chk("R2 readback", VEC[i][12:8], VEC[i][7:0]);
      else            reg_wr(VEC[i][12:8], VEC[i][7:0]);
    end
    settle;
    chk("R2 baud out", link_baud_div, 16'h1234);
    chk("R2 frame out", link_frame_cfg, 8'h15);
    chk("R2 rx_en", link_rx_en, 1);
    chk("R2 tx_en", link_tx_en, 0);
    rd_chk("R8 no tx flag while tx off", 5'h1F, 8'h00);

    // R3 / R10: fill TX FIFO with tx disabled
    for (int i = 0; i < 16; i++) begin
      reg_wr(5'h04, 8'hA0 + 8'(i));
      rd_chk("R10 R3 fifo status", 5'h0A,
             8'h04 | ((i + 1 <= 8) ? 8'h80 : 8'h00) | ((i + 1 == 16) ? 8'h10 : 8'h00));
    end
    reg_wr(5'h04, 8'hFF);
    rd_chk("R5 not drained", 5'h02, 8'h00);
    settle;
    chk("R2 tx_valid off", link_tx_valid, 0);
    reg_wr(5'h01, 8'h03);
    rd_chk("R8 full blocks tx flag", 5'h1F, 8'h00);
    for (int i = 0; i < 16; i++) begin
      settle;
      chk("R3 tx valid", link_tx_valid, 1);
      chk("R3 tx order", link_tx_byte, 8'hA0 + 8'(i));
      take;
    end
    settle;
    chk("R3 overflow byte dropped", link_tx_valid, 0);
    rd_chk("R8 tx flag raised", 5'h1F, 8'h01);
    settle;
    chk("R7 irq on", irq, 1);
    rd_chk("R5 drained", 5'h02, 8'h40);
    link_tx_busy = 1'b1;
    rd_chk("R5 busy not drained", 5'h02, 8'h00);
    link_tx_busy = 1'b0;

    // R7: flag set / clear / enable
    reg_wr(5'h01, 8'h01);
    reg_wr(5'h1C, 8'h01);
    rd_chk("R7 cleared", 5'h1F, 8'h00);
    settle;
    chk("R7 irq off", irq, 0);
    reg_wr(5'h1D, 8'h02);
    rd_chk("R7 forced rx", 5'h1F, 8'h02);
    reg_wr(5'h1E, 8'h01);
    rd_chk("R7 masked", 5'h1F, 8'h00);
    settle;
    chk("R7 irq masked", irq, 0);
    reg_wr(5'h1E, 8'h03);
    reg_wr(5'h1C, 8'h02);
    rd_chk("R7 rx cleared", 5'h1F, 8'h00);

    // R6: receive threshold (cfg 0x8B: mode on, t=3 -> mark 11)
    for (int i = 0; i < 11; i++) rx_in(8'h30 + 8'(i), 2'(i));
    rd_chk("R6 at mark", 5'h0A, 8'h80);
    rd_chk("R8 rx below mark", 5'h1F, 8'h00);
    rx_in(8'h3B, 2'd3);
    rd_chk("R6 above mark", 5'h0A, 8'h88);
    rd_chk("R8 rx flag", 5'h1F, 8'h02);
    reg_wr(5'h0B, 8'h03);
    rd_chk("R6 mode off", 5'h0A, 8'h88);
    reg_wr(5'h0B, 8'h0F);
    rd_chk("R6 t=7", 5'h0A, 8'h80);
    reg_wr(5'h0B, 8'h08);
    rd_chk("R6 t=0", 5'h0A, 8'h88);

    // R4 / R5: read out with error bits
    for (int i = 0; i < 12; i++) begin
      rd_chk("R5 head errors", 5'h02, 8'h40 | 8'(i % 4));
      rd_chk("R4 rx order", 5'h04, 8'h30 + 8'(i));
    end
    rd_chk("R4 empty read", 5'h04, 8'h00);
    rd_chk("R4 empty status", 5'h0A, 8'h84);

    // R4: overrun
    for (int i = 0; i < 16; i++) rx_in(8'h50 + 8'(i), 2'd0);
    rx_in(8'hEE, 2'd0);
    rd_chk("R4 first after full", 5'h04, 8'h50);
    rx_in(8'h77, 2'd0);
    for (int i = 1; i < 16; i++) rd_chk("R4 full order", 5'h04, 8'h50 + 8'(i));
    rd_chk("R4 overrun mark", 5'h02, 8'h44);
    rd_chk("R4 overrun byte", 5'h04, 8'h77);
    rd_chk("R4 mark consumed", 5'h02, 8'h40);

    // R9: soft reset and block disable
    reg_wr(5'h01, 8'h03);
    reg_wr(5'h04, 8'h11);
    reg_wr(5'h04, 8'h22);
    rx_in(8'h99, 2'd0);
    rx_in(8'h9A, 2'd0);
    reg_wr(5'h1D, 8'h03);
    settle;
    chk("R9 pre irq", irq, 1);
    reg_wr(5'h01, 8'h07);
    rd_chk("R9 fifos flushed", 5'h0A, 8'h84);
    rd_chk("R9 flags wiped", 5'h1F, 8'h00);
    settle;
    chk("R9 irq low", irq, 0);
    chk("R9 tx_valid low", link_tx_valid, 0);
    chk("R9 divisor kept", link_baud_div, 16'h1234);
    reg_wr(5'h01, 8'h03);
    reg_wr(5'h00, 8'h00);
    rx_in(8'h42, 2'd0);
    reg_wr(5'h04, 8'h55);
    reg_wr(5'h00, 8'h01);
    rd_chk("R9 pushes ignored", 5'h0A, 8'h84);
    settle;
    chk("R9 tx write ignored", link_tx_valid, 0);
    rd_chk("R9 ctrl kept", 5'h01, 8'h03);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule